// File: doc/BRIEF.md
# Exception Entry and Exit Sequencer with Handler Chaining

This block times the entry into and exit from interrupt handlers for a small processor core. The pending-request logic outside it has already picked the most urgent request, and it presents that request's vector number and priority (a lower number is more urgent). The sequencer saves the interrupted context as eight abstract push beats, issues a vector fetch strobe and runs the handler. It keeps a stack of the priorities of nested active handlers and reports whether any handler is active. On a return strobe it restores the context with eight pop beats. The outside logic treats the fetch strobe as acceptance of the request it offered.

Three shortcuts cut the overhead. If a request is waiting when a handler returns, and it would run ahead of whatever was interrupted, the sequencer skips the restore and the save and goes straight to the next vector. A more urgent request that shows up while the context is being saved takes over the entry already in progress without restarting it. A qualifying request that shows up while the context is being restored cancels the restore and starts a new entry at once. A phase code on the ports shows where the sequencer is on every cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted and after it is released, phase reads idle, no push, pop or fetch strobe is asserted, and handler_active is low.
- R2: An accepted request leads to 12 cycles of phase stack (1), then one cycle of phase fetch (2), then phase run (3). Push beats come on the first 8 stacking cycles with word index 0..7 (0..3 = R0..R3, 4 = R12, 5 = LR, 6 = PC, 7 = xPSR). fetch_vec carries the target vector during the fetch cycle, and handler_active is high from the cycle after the fetch.
- R3: During stacking or chaining, a request whose priority number is strictly lower than the current target's replaces the target. Stacking is not restarted and still lasts 12 cycles in total, and the fetch carries the new vector.
- R4: In phase idle any request is accepted. In phase run a request is accepted (preemption) only if its priority number is strictly lower than the running handler's, and only while fewer than 8 handlers are nested. An equal or larger number leaves the phase at run.
- R5: A return strobe is acted on only in phase run: code 0xFFFFFFF9 when exactly one handler is active, code 0xFFFFFFF1 when two or more are active. Any other code or combination is ignored, and the phase stays run.
- R6: If, at an accepted return, a request is pending and either the code is 0xFFFFFFF9 or the request's priority number is strictly lower than the interrupted handler's, the sequencer spends 6 cycles in phase chain (4) with no push or pop beats and handler_active high, then fetches the pending vector and runs it.
- R7: Any other accepted return gives 12 cycles of phase unstack (5), with pop beats on the first 8 cycles in the same word index order as R2. The phase then becomes run if a handler remains active, or idle otherwise.
- R8: During unstacking, a request that R4 would accept against the handler being returned to cancels the restore. Stacking starts on the next cycle with push index 0.
- R9: The phase code uses idle 0, stack 1, fetch 2, run 3, chain 4, unstack 5, and push and pop beats are never asserted together.
- R10: handler_active is high exactly while the nesting stack holds at least one handler, and it stays high through a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered (the most urgent pending one) |
| req_vec | input | VEC_W | Vector number of the offered request |
| req_pri | input | PRI_W | Priority of the offered request; lower is more urgent |
| ret_valid | input | 1 | Return-from-handler strobe |
| ret_code | input | 32 | Return code presented with the strobe |
| push_valid | output | 1 | Context save beat |
| push_idx | output | $clog2(WORDS) | Word index of the save beat |
| pop_valid | output | 1 | Context restore beat |
| pop_idx | output | $clog2(WORDS) | Word index of the restore beat |
| fetch_valid | output | 1 | Vector fetch strobe; acceptance of the target request |
| fetch_vec | output | VEC_W | Vector being fetched |
| handler_active | output | 1 | At least one handler is active |
| phase | output | 3 | Current phase code |

## Verification
Every output is a registered state decoded directly, so a request or return presented before a clock edge shows its effect in the phase just after that edge. The first stacking, chaining or unstacking cycle is visible one cycle after the stimulus. The fetch follows 12 stacking cycles or 6 chaining cycles, and run follows the fetch by one cycle. The bench changes inputs and samples outputs one time unit after each rising edge, and it walks each phase one cycle at a time. A shortened or stretched phase, a beat index out of order, or a late-arrival or pop-preemption decision taken one cycle off therefore shows up at the exact sample where it happens. Retargeting and cancellation are injected after a known number of observed phase cycles, so the cycle on which the sequencer must react is fixed in advance.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_STACK   = 3'd1,
    PH_FETCH   = 3'd2,
    PH_RUN     = 3'd3,
    PH_CHAIN   = 3'd4,
    PH_UNSTACK = 3'd5
  } phase_e;

  localparam logic [31:0] RET_TO_HANDLER = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_TO_THREAD  = 32'hFFFF_FFF9;

endpackage

// File: rtl/exc_prio_nest.sv
module exc_prio_nest #(
  parameter int NEST_DEPTH = 8,
  parameter int PRI_W      = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_en,
  input  logic                             pop_en,
  input  logic                             repl_en,
  input  logic [PRI_W-1:0]                 pri_in,
  output logic [$clog2(NEST_DEPTH+1)-1:0]  depth_o,
  output logic [PRI_W-1:0]                 top_o,
  output logic [PRI_W-1:0]                 below_o,
  output logic                             full_o,
  output logic                             empty_o
);

  localparam int DW = $clog2(NEST_DEPTH+1);

  logic [DW-1:0]                   depth_q, depth_d;
  logic                            depth_en;
  logic [NEST_DEPTH-1:0][PRI_W-1:0] slot_q;
  logic [NEST_DEPTH-1:0]           slot_wr;

  // next depth
  always_comb begin
    depth_en = push_en ^ pop_en;
    depth_d  = depth_q;
    if (push_en && !pop_en)      depth_d = depth_q + DW'(1);
    else if (pop_en && !push_en) depth_d = depth_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth_q <= '0;
    else if (depth_en) depth_q <= depth_d;
  end

  // per-slot write enables: push fills the slot above the top, replace overwrites the top
  for (genvar g = 0; g < NEST_DEPTH; g++) begin : g_wr
    assign slot_wr[g] = (push_en && depth_q == DW'(g)) ||
                        (repl_en && depth_q == DW'(g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      for (int i = 0; i < NEST_DEPTH; i++) begin
        if (slot_wr[i]) slot_q[i] <= pri_in;
      end
    end
  end

  // top and next-below priorities; an absent level reads as least urgent
  always_comb begin
    top_o   = '1;
    below_o = '1;
    for (int i = 0; i < NEST_DEPTH; i++) begin
      if (depth_q == DW'(i + 1)) top_o   = slot_q[i];
      if (depth_q == DW'(i + 2)) below_o = slot_q[i];
    end
  end

  assign depth_o = depth_q;
  assign full_o  = (depth_q == DW'(NEST_DEPTH));
  assign empty_o = (depth_q == '0);

endmodule

// File: rtl/exc_beat_gen.sv
module exc_beat_gen
  import exc_seq_pkg::*;
#(
  parameter int STACK_CYC = 12,
  parameter int WORDS     = 8
) (
  input  phase_e                         phase_i,
  input  logic [$clog2(STACK_CYC)-1:0]   cnt_i,
  output logic                           push_valid,
  output logic [$clog2(WORDS)-1:0]       push_idx,
  output logic                           pop_valid,
  output logic [$clog2(WORDS)-1:0]       pop_idx,
  output logic                           fetch_valid
);

  localparam int CW  = $clog2(STACK_CYC);
  localparam int WIW = $clog2(WORDS);

  logic in_words;

  assign in_words    = (cnt_i < CW'(WORDS));
  assign push_valid  = (phase_i == PH_STACK)   && in_words;
  assign pop_valid   = (phase_i == PH_UNSTACK) && in_words;
  assign push_idx    = push_valid ? WIW'(cnt_i) : '0;
  assign pop_idx     = pop_valid  ? WIW'(cnt_i) : '0;
  assign fetch_valid = (phase_i == PH_FETCH);

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int VEC_W      = 5,
  parameter int PRI_W      = 4,
  parameter int NEST_DEPTH = 8,
  parameter int STACK_CYC  = 12,
  parameter int CHAIN_CYC  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [VEC_W-1:0]                 req_vec,
  input  logic [PRI_W-1:0]                 req_pri,
  input  logic                             ret_valid,
  input  logic [31:0]                      ret_code,
  input  logic [$clog2(NEST_DEPTH+1)-1:0]  nest_depth,
  input  logic [PRI_W-1:0]                 nest_top,
  input  logic [PRI_W-1:0]                 nest_below,
  input  logic                             nest_full,
  input  logic                             nest_empty,
  output phase_e                           phase_o,
  output logic [$clog2(STACK_CYC)-1:0]     cnt_o,
  output logic [VEC_W-1:0]                 tgt_vec_o,
  output logic [PRI_W-1:0]                 tgt_pri_o,
  output logic                             nest_push,
  output logic                             nest_pop,
  output logic                             nest_repl
);

  localparam int DW = $clog2(NEST_DEPTH+1);
  localparam int CW = $clog2(STACK_CYC);
  localparam logic [CW-1:0] STACK_LAST = CW'(STACK_CYC - 1);
  localparam logic [CW-1:0] CHAIN_LAST = CW'(CHAIN_CYC - 1);

  phase_e            ph_q, ph_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [PRI_W-1:0]  pri_q, pri_d;
  logic              chain_q, chain_d;
  logic              tgt_en;

  logic can_take, late_hit, ret_ok, chain_hit;

  // decisions on the offered request and the return strobe
  always_comb begin
    can_take  = req_valid && !nest_full && (nest_empty || (req_pri < nest_top));
    late_hit  = req_valid && (req_pri < pri_q);
    ret_ok    = ret_valid &&
                (((ret_code == RET_TO_THREAD)  && (nest_depth == DW'(1))) ||
                 ((ret_code == RET_TO_HANDLER) && (nest_depth >= DW'(2))));
    chain_hit = req_valid && ((ret_code == RET_TO_THREAD) || (req_pri < nest_below));
  end

  // next state
  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    vec_d     = vec_q;
    pri_d     = pri_q;
    chain_d   = chain_q;
    tgt_en    = 1'b0;
    nest_push = 1'b0;
    nest_pop  = 1'b0;
    nest_repl = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (can_take) begin
          ph_d = PH_STACK; cnt_d = '0; tgt_en = 1'b1; chain_d = 1'b0;
        end
      end
      PH_STACK: begin
        tgt_en = late_hit;
        if (cnt_q == STACK_LAST) begin
          ph_d = PH_FETCH; cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_FETCH: begin
        nest_repl = chain_q;
        nest_push = !chain_q;
        ph_d      = PH_RUN;
      end
      PH_RUN: begin
        if (ret_ok) begin
          cnt_d = '0;
          if (chain_hit) begin
            ph_d = PH_CHAIN; tgt_en = 1'b1; chain_d = 1'b1;
          end else begin
            ph_d = PH_UNSTACK; nest_pop = 1'b1;
          end
        end else if (can_take) begin
          ph_d = PH_STACK; cnt_d = '0; tgt_en = 1'b1; chain_d = 1'b0;
        end
      end
      PH_CHAIN: begin
        tgt_en = late_hit;
        if (cnt_q == CHAIN_LAST) begin
          ph_d = PH_FETCH; cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_UNSTACK: begin
        if (can_take) begin
          ph_d = PH_STACK; cnt_d = '0; tgt_en = 1'b1; chain_d = 1'b0;
        end else if (cnt_q == STACK_LAST) begin
          ph_d  = nest_empty ? PH_IDLE : PH_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d = PH_IDLE; cnt_d = '0;
      end
    endcase
    if (tgt_en) begin
      vec_d = req_vec;
      pri_d = req_pri;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      chain_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pri_q <= '1;
    end else if (tgt_en) begin
      vec_q <= vec_d;
      pri_q <= pri_d;
    end
  end

  assign phase_o   = ph_q;
  assign cnt_o     = cnt_q;
  assign tgt_vec_o = vec_q;
  assign tgt_pri_o = pri_q;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int VEC_W      = 5,
  parameter int PRI_W      = 4,
  parameter int NEST_DEPTH = 8,
  parameter int STACK_CYC  = 12,
  parameter int CHAIN_CYC  = 6,
  parameter int WORDS      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VEC_W-1:0]           req_vec,
  input  logic [PRI_W-1:0]           req_pri,
  input  logic                       ret_valid,
  input  logic [31:0]                ret_code,
  output logic                       push_valid,
  output logic [$clog2(WORDS)-1:0]   push_idx,
  output logic                       pop_valid,
  output logic [$clog2(WORDS)-1:0]   pop_idx,
  output logic                       fetch_valid,
  output logic [VEC_W-1:0]           fetch_vec,
  output logic                       handler_active,
  output logic [2:0]                 phase
);

  localparam int DW = $clog2(NEST_DEPTH+1);
  localparam int CW = $clog2(STACK_CYC);

  phase_e            ph;
  logic [CW-1:0]     cnt;
  logic [VEC_W-1:0]  tgt_vec;
  logic [PRI_W-1:0]  tgt_pri;
  logic              n_push, n_pop, n_repl;
  logic [DW-1:0]     n_depth;
  logic [PRI_W-1:0]  n_top, n_below;
  logic              n_full, n_empty;

  exc_seq_ctrl #(
    .VEC_W(VEC_W), .PRI_W(PRI_W), .NEST_DEPTH(NEST_DEPTH),
    .STACK_CYC(STACK_CYC), .CHAIN_CYC(CHAIN_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec), .req_pri(req_pri),
    .ret_valid(ret_valid), .ret_code(ret_code),
    .nest_depth(n_depth), .nest_top(n_top), .nest_below(n_below),
    .nest_full(n_full), .nest_empty(n_empty),
    .phase_o(ph), .cnt_o(cnt), .tgt_vec_o(tgt_vec), .tgt_pri_o(tgt_pri),
    .nest_push(n_push), .nest_pop(n_pop), .nest_repl(n_repl)
  );

  exc_prio_nest #(
    .NEST_DEPTH(NEST_DEPTH), .PRI_W(PRI_W)
  ) u_nest (
    .clk(clk), .rst_n(rst_n),
    .push_en(n_push), .pop_en(n_pop), .repl_en(n_repl), .pri_in(tgt_pri),
    .depth_o(n_depth), .top_o(n_top), .below_o(n_below),
    .full_o(n_full), .empty_o(n_empty)
  );

  exc_beat_gen #(
    .STACK_CYC(STACK_CYC), .WORDS(WORDS)
  ) u_beats (
    .phase_i(ph), .cnt_i(cnt),
    .push_valid(push_valid), .push_idx(push_idx),
    .pop_valid(pop_valid), .pop_idx(pop_idx),
    .fetch_valid(fetch_valid)
  );

  assign fetch_vec      = tgt_vec;
  assign handler_active = !n_empty;
  assign phase          = ph;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int WORDS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      push_valid,
  input logic [$clog2(WORDS)-1:0]  push_idx,
  input logic                      pop_valid,
  input logic [$clog2(WORDS)-1:0]  pop_idx,
  input logic                      fetch_valid,
  input logic                      handler_active,
  input logic [2:0]                phase
);

  localparam int WIW = $clog2(WORDS);
  localparam logic [WIW-1:0] LAST_IDX = WIW'(WORDS - 1);

  assert_fetch_to_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |=> (phase == PH_RUN));

  assert_fetch_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ($past(phase) == PH_STACK || $past(phase) == PH_CHAIN));

  assert_push_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_idx != LAST_IDX) |=>
      (push_valid && push_idx == WIW'($past(push_idx) + 1'b1)));

  assert_push_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_valid) |-> (push_idx == '0));

  assert_chain_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHAIN) |-> (!push_valid && !pop_valid && !fetch_valid && handler_active));

  assert_pop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_idx != LAST_IDX) |=>
      ((pop_valid && pop_idx == WIW'($past(pop_idx) + 1'b1)) || phase == PH_STACK));

  assert_phase_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= PH_UNSTACK) && !(push_valid && pop_valid));

  assert_idle_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !handler_active);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .push_valid(push_valid), .push_idx(push_idx),
  .pop_valid(pop_valid), .pop_idx(pop_idx),
  .fetch_valid(fetch_valid), .handler_active(handler_active),
  .phase(phase)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 5;
  localparam int PRI_W = 4;
  localparam int WDOG  = 20000;

  localparam logic [2:0] P_IDLE = 3'd0, P_STACK = 3'd1, P_FETCH = 3'd2,
                         P_RUN = 3'd3, P_CHAIN = 3'd4, P_UNSTACK = 3'd5;
  localparam logic [31:0] C_HND = 32'hFFFF_FFF1;
  localparam logic [31:0] C_THR = 32'hFFFF_FFF9;

  // table: {vector, priority} for single entry/exit runs
  localparam int NTBL = 4;
  localparam logic [8:0] TBL [NTBL] = '{ {5'd3, 4'd5}, {5'd0, 4'd0},
                                         {5'd31, 4'd15}, {5'd17, 4'd9} };

  logic clk, rst_n;
  logic req_valid, ret_valid;
  logic [VEC_W-1:0] req_vec, fetch_vec;
  logic [PRI_W-1:0] req_pri;
  logic [31:0] ret_code;
  logic push_valid, pop_valid, fetch_valid, handler_active;
  logic [2:0] push_idx, pop_idx, phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec), .req_pri(req_pri),
    .ret_valid(ret_valid), .ret_code(ret_code),
    .push_valid(push_valid), .push_idx(push_idx),
    .pop_valid(pop_valid), .pop_idx(pop_idx),
    .fetch_valid(fetch_valid), .fetch_vec(fetch_vec),
    .handler_active(handler_active), .phase(phase)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_phase(input logic [2:0] exp, input string tag);
    chk(phase == exp, tag, phase, exp);
  endtask

  // offer a request, walk stacking, optionally inject a late request at stacking cycle late_k
  task automatic do_entry(input logic [4:0] vec, input logic [3:0] pri, input int late_k,
                          input logic [4:0] lvec, input logic [3:0] lpri, input logic [4:0] exp_vec);
    req_valid = 1'b1; req_vec = vec; req_pri = pri;
    tick();
    for (int k = 0; k < 12; k++) begin
      chk_phase(P_STACK, "R2 stacking phase");
      chk(push_valid == (k < 8), "R2 push beat", push_valid, k < 8);
      if (k < 8) chk(push_idx == 3'(k), "R2 push index order", push_idx, k);
      if (k == late_k) begin
        req_vec = lvec; req_pri = lpri;
      end
      tick();
    end
    chk_phase(P_FETCH, "R2 fetch after 12 stacking cycles");
    chk(fetch_valid && fetch_vec == exp_vec, "R2/R3 fetched vector", fetch_vec, exp_vec);
    req_valid = 1'b0;
    tick();
    chk_phase(P_RUN, "R2 run after fetch");
    chk(handler_active, "R10 handler active in run", handler_active, 1);
  endtask

  task automatic do_ret(input logic [31:0] code);
    ret_valid = 1'b1; ret_code = code;
    tick();
    ret_valid = 1'b0; ret_code = '0;
  endtask

  task automatic do_unstack(input logic [2:0] exp_end);
    for (int k = 0; k < 12; k++) begin
      chk_phase(P_UNSTACK, "R7 unstacking phase");
      chk(pop_valid == (k < 8), "R7 pop beat", pop_valid, k < 8);
      if (k < 8) chk(pop_idx == 3'(k), "R7 pop index order", pop_idx, k);
      tick();
    end
    chk_phase(exp_end, "R7 phase after unstacking");
    chk(handler_active == (exp_end != P_IDLE), "R10 active after exit", handler_active, exp_end != P_IDLE);
  endtask

  task automatic do_chain(input logic [4:0] exp_vec);
    for (int k = 0; k < 6; k++) begin
      chk_phase(P_CHAIN, "R6 chain phase");
      chk(!push_valid && !pop_valid, "R6 no beats in chain", push_valid | pop_valid, 0);
      chk(handler_active, "R10 active through chain", handler_active, 1);
      tick();
    end
    chk_phase(P_FETCH, "R6 fetch after 6 chain cycles");
    chk(fetch_valid && fetch_vec == exp_vec, "R6 chained vector", fetch_vec, exp_vec);
    req_valid = 1'b0;
    tick();
    chk_phase(P_RUN, "R6 run after chain");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vec = '0; req_pri = '0;
    ret_valid = 1'b0; ret_code = '0;
    repeat (3) tick();
    // R1 during reset
    chk(phase == P_IDLE && !push_valid && !pop_valid && !fetch_valid && !handler_active,
        "R1 outputs in reset", phase, P_IDLE);
    rst_n = 1'b1;
    tick();
    chk(phase == P_IDLE && !push_valid && !pop_valid && !fetch_valid && !handler_active,
        "R1 outputs after reset", phase, P_IDLE);

    // R5: return while idle is ignored
    do_ret(C_THR);
    chk_phase(P_IDLE, "R5 return ignored when idle");

    // table walk: plain entry then plain exit
    for (int i = 0; i < NTBL; i++) begin
      do_entry(TBL[i][8:4], TBL[i][3:0], -1, '0, '0, TBL[i][8:4]);
      do_ret(32'hFFFF_FFFD);
      chk_phase(P_RUN, "R5 unknown code ignored");
      do_ret(C_HND);
      chk_phase(P_RUN, "R5 handler code at depth 1 ignored");
      do_ret(C_THR);
      do_unstack(P_IDLE);
    end

    // R3 late arrival then R6 chaining of the original request
    do_entry(5'd1, 4'd6, 3, 5'd9, 4'd2, 5'd9);
    req_valid = 1'b1; req_vec = 5'd1; req_pri = 4'd6;
    tick();
    chk_phase(P_RUN, "R4 less urgent request does not preempt");
    do_ret(C_THR);
    do_chain(5'd1);
    do_ret(C_THR);
    do_unstack(P_IDLE);

    // R8 pop preemption after three unstacking cycles
    do_entry(5'd2, 4'd4, -1, '0, '0, 5'd2);
    do_ret(C_THR);
    for (int k = 0; k < 3; k++) begin
      chk(phase == P_UNSTACK && pop_idx == 3'(k), "R8 unstack before cancel", pop_idx, k);
      tick();
    end
    chk(pop_valid && pop_idx == 3'd3, "R8 pop in progress", pop_idx, 3);
    do_entry(5'd5, 4'd7, -1, '0, '0, 5'd5);
    do_ret(C_THR);
    do_unstack(P_IDLE);

    // R4 nesting, R5 code checks, R6 chain refused in favour of interrupted handler
    do_entry(5'd2, 4'd4, -1, '0, '0, 5'd2);
    req_valid = 1'b1; req_vec = 5'd3; req_pri = 4'd4;
    tick();
    chk_phase(P_RUN, "R4 equal priority does not preempt");
    do_entry(5'd8, 4'd1, -1, '0, '0, 5'd8);
    do_ret(C_THR);
    chk_phase(P_RUN, "R5 thread code at depth 2 ignored");
    req_valid = 1'b1; req_vec = 5'd6; req_pri = 4'd6;
    do_ret(C_HND);
    chk_phase(P_UNSTACK, "R6 no chain below interrupted priority");
    do_unstack(P_RUN);
    do_ret(C_THR);
    chk_phase(P_CHAIN, "R6 chain on thread return");
    tick();
    // one cycle into chain already passed; walk the rest
    for (int k = 1; k < 6; k++) begin
      chk_phase(P_CHAIN, "R6 chain phase");
      tick();
    end
    chk(fetch_valid && fetch_vec == 5'd6, "R6 chained vector", fetch_vec, 6);
    req_valid = 1'b0;
    tick();
    do_ret(C_THR);
    do_unstack(P_IDLE);

    // R6 chain on handler return when pending beats the interrupted handler
    do_entry(5'd2, 4'd4, -1, '0, '0, 5'd2);
    do_entry(5'd8, 4'd1, -1, '0, '0, 5'd8);
    req_valid = 1'b1; req_vec = 5'd11; req_pri = 4'd3;
    do_ret(C_HND);
    do_chain(5'd11);
    do_ret(C_HND);
    do_unstack(P_RUN);
    do_ret(C_THR);
    do_unstack(P_IDLE);

    // R4 nesting limit of 8
    for (int i = 0; i < 8; i++) do_entry(5'(i), 4'(14 - i), -1, '0, '0, 5'(i));
    req_valid = 1'b1; req_vec = 5'd20; req_pri = 4'd0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(phase == P_RUN && !push_valid, "R4 no preemption when nest full", phase, P_RUN);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 7; i++) begin
      do_ret(C_HND);
      do_unstack(P_RUN);
    end
    do_ret(C_THR);
    do_unstack(P_IDLE);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule